// File: doc/BRIEF.md
# Sticky Alignment Right Shifter

This block aligns the significand of an unpacked floating-point operand ahead of an add or subtract. It shifts a 128-bit significand (four 32-bit words) right by an unsigned count. A guard ("round") bit and an accumulating "sticky" bit together record everything that falls off the low end, so later rounding can be exact. Ones never enter from the top; zeros fill the vacated high positions.

The shift is built as a whole-word step of multiples of 32 positions followed by a residual step below one word. The combined round/sticky result is the same as a single shift by the full count. Counts past the usable range (above 113) collapse the operand. An all-zero normal operand becomes the zero class. Any other normal operand becomes an empty significand with only the sticky bit set. Operands of any class other than normal pass through untouched.

One operand is taken per valid/ready transfer. The result is registered and offered one cycle after acceptance. Sign and exponent travel alongside unchanged.

Top module: `sas_top`

## Requirements
- R1: A normal operand with shift count 0 leaves significand, round, sticky and class unchanged.
- R2: For a normal operand and count n in 1..113, the output significand equals the input significand shifted right by n, with zeros filling the top n bits.
- R3: For a normal operand and count n in 1..113, the output round bit equals input significand bit n-1 (bit 0 is the least significant bit of the 128-bit value).
- R4: For a normal operand and count n in 1..113, the output sticky bit is the OR of the input sticky, the input round, and input significand bits n-2 down to 0.
- R5: A normal operand (class code 1) with count above 113 and an all-zero significand leaves with class code 0 (zero), an all-zero significand, and round and sticky unchanged.
- R6: A normal operand with count above 113 and a nonzero significand leaves with class normal, an all-zero significand, round 0 and sticky 1.
- R7: Operands whose class code is not 1 (0 zero, 2 infinity, 3 NaN) leave with class, significand, round and sticky unchanged, for any count.
- R8: An operand accepted on a clock edge (in_valid and in_ready both high) appears on the outputs with out_valid high after that edge, with sign and exponent equal to the inputs.
- R9: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready low, the outputs hold their values.

Class codes are two bits: 0 zero, 1 normal, 2 infinity, 3 NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operand offered |
| in_ready | output | 1 | Block can take an operand |
| in_sign | input | 1 | Operand sign, passed through |
| in_exp | input | EXP_W (16) | Operand exponent, passed through |
| in_class | input | 2 | Operand class code |
| in_sig | input | 128 | Operand significand |
| in_round | input | 1 | Incoming round bit |
| in_sticky | input | 1 | Incoming sticky bit |
| in_shift | input | CNT_W (8) | Right shift count |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W (16) | Result exponent |
| out_class | output | 2 | Result class code |
| out_sig | output | 128 | Shifted significand |
| out_round | output | 1 | Updated round bit |
| out_sticky | output | 1 | Updated sticky bit |

## Verification
The bench aims at the counts where the word and residual steps meet: 31, 32, 33, 64, 96 and 113, plus 114 and 255 just past the limit. A design that drops the old round bit into nothing, or takes the round bit from the wrong side of a word boundary, gives a wrong round or sticky there. A zero normal operand with an over-range count must turn into the zero class. A design that treats it like a nonzero one would raise sticky instead. Infinity and NaN with large counts must pass intact; a design that shifts them corrupts their payload. A held result under backpressure must stay stable, and in_ready must drop, or a second operand would overwrite the first.

// File: rtl/sas_pkg.sv
package sas_pkg;

    parameter int WORD_W  = 32;
    parameter int NWORDS  = 4;
    localparam int SIG_W  = WORD_W * NWORDS;
    localparam int RES_W  = $clog2(WORD_W);
    localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    typedef enum logic [1:0] {
        CLS_ZERO   = 2'd0,
        CLS_NORMAL = 2'd1,
        CLS_INF    = 2'd2,
        CLS_NAN    = 2'd3
    } cls_e;

    typedef struct packed {
        logic [SIG_W-1:0] sig;
        logic             rnd;
        logic             stk;
    } frac_t;

    // Mask with the lowest n bits set (n below SIG_W).
    function automatic logic [SIG_W-1:0] low_ones(input logic [RES_W-1:0] n);
        logic [SIG_W-1:0] one;
        one = {{(SIG_W-1){1'b0}}, 1'b1};
        return (one << n) - one;
    endfunction

endpackage

// File: rtl/sas_word_shift.sv
module sas_word_shift
    import sas_pkg::*;
(
    input  frac_t             frac_i,
    input  logic [WSEL_W-1:0] words_i,
    output frac_t             frac_o
);

    frac_t cand [NWORDS];

    genvar k;
    generate
        for (k = 0; k < NWORDS; k++) begin : g_step
            if (k == 0) begin : g_none
                assign cand[k] = frac_i;
            end else begin : g_move
                assign cand[k].sig = frac_i.sig >> (k * WORD_W);
                assign cand[k].rnd = frac_i.sig[k*WORD_W-1];
                assign cand[k].stk = frac_i.stk | frac_i.rnd
                                   | (|frac_i.sig[k*WORD_W-2:0]);
            end
        end
    endgenerate

    always_comb begin
        frac_o = cand[0];
        for (int i = 1; i < NWORDS; i++) begin
            if (words_i == WSEL_W'(i)) frac_o = cand[i];
        end
    end

endmodule

// File: rtl/sas_bit_shift.sv
module sas_bit_shift
    import sas_pkg::*;
(
    input  frac_t            frac_i,
    input  logic [RES_W-1:0] bits_i,
    output frac_t            frac_o
);

    logic [RES_W-1:0] last_pos;

    always_comb begin
        last_pos = bits_i - 1'b1;
        frac_o   = frac_i;
        if (bits_i != '0) begin
            frac_o.sig = frac_i.sig >> bits_i;
            frac_o.rnd = frac_i.sig[last_pos];
            frac_o.stk = frac_i.stk | frac_i.rnd
                       | (|(frac_i.sig & low_ones(last_pos)));
        end
    end

endmodule

// File: rtl/sas_top.sv
module sas_top
    import sas_pkg::*;
#(
    parameter int EXP_W = 16,
    parameter int CNT_W = 8,
    parameter int LIMIT = 113
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sign,
    input  logic [EXP_W-1:0] in_exp,
    input  logic [1:0]       in_class,
    input  logic [SIG_W-1:0] in_sig,
    input  logic             in_round,
    input  logic             in_sticky,
    input  logic [CNT_W-1:0] in_shift,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_sign,
    output logic [EXP_W-1:0] out_exp,
    output logic [1:0]       out_class,
    output logic [SIG_W-1:0] out_sig,
    output logic             out_round,
    output logic             out_sticky
);

    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

    logic              accept;
    logic              over;
    logic              is_norm;
    frac_t             f_in, f_word, f_bits, f_res;
    cls_e              cls_res;
    logic [WSEL_W-1:0] wsel;
    logic [RES_W-1:0]  bsel;

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;
    assign is_norm  = (in_class == CLS_NORMAL);
    assign over     = (in_shift > LIM_C);

    assign f_in = '{sig: in_sig, rnd: in_round, stk: in_sticky};
    assign wsel = WSEL_W'(in_shift >> RES_W);
    assign bsel = in_shift[RES_W-1:0];

    sas_word_shift u_word (
        .frac_i (f_in),
        .words_i(wsel),
        .frac_o (f_word)
    );

    sas_bit_shift u_bits (
        .frac_i(f_word),
        .bits_i(bsel),
        .frac_o(f_bits)
    );

    always_comb begin
        f_res   = f_in;
        cls_res = cls_e'(in_class);
        if (is_norm) begin
            if (over) begin
                if (in_sig == '0) begin
                    cls_res = CLS_ZERO;
                end else begin
                    f_res = '{sig: '0, rnd: 1'b0, stk: 1'b1};
                end
            end else begin
                f_res = f_bits;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sign   <= 1'b0;
            out_exp    <= '0;
            out_class  <= CLS_ZERO;
            out_sig    <= '0;
            out_round  <= 1'b0;
            out_sticky <= 1'b0;
        end else begin
            if (accept) begin
                out_valid  <= 1'b1;
                out_sign   <= in_sign;
                out_exp    <= in_exp;
                out_class  <= cls_res;
                out_sig    <= f_res.sig;
                out_round  <= f_res.rnd;
                out_sticky <= f_res.stk;
            end else if (out_ready) begin
                out_valid  <= 1'b0;
            end
        end
    end

    // R1: zero count is an identity on a normal operand
    p_noshift_r1: assert property (@(posedge clk) disable iff (rst)
        (accept && is_norm && in_shift == '0) |=>
        (out_sig == $past(in_sig) && out_round == $past(in_round)
         && out_sticky == $past(in_sticky) && out_class == CLS_NORMAL));

    // R5: empty normal operand past the limit becomes zero class
    p_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && is_norm && over && in_sig == '0) |=>
        (out_class == CLS_ZERO && out_sig == '0
         && out_round == $past(in_round) && out_sticky == $past(in_sticky)));

    // R6: nonzero normal operand past the limit keeps only sticky
    p_overrange_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && is_norm && over && in_sig != '0) |=>
        (out_sig == '0 && !out_round && out_sticky && out_class == CLS_NORMAL));

    // R7: non-normal classes untouched
    p_passthru_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && !is_norm) |=>
        (out_sig == $past(in_sig) && out_class == $past(in_class)
         && out_round == $past(in_round) && out_sticky == $past(in_sticky)));

    // R8: result appears one cycle after acceptance with sign/exponent intact
    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_valid && out_exp == $past(in_exp)
                    && out_sign == $past(in_sign)));

    // R9: held result stays stable under backpressure
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_sig) && $stable(out_round)
         && $stable(out_sticky) && $stable(out_class) && $stable(out_exp)));

    // R2: zeros fill the top for in-range shifts
    p_topfill_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && is_norm && !over && in_shift != '0) |=>
        (out_sig[SIG_W-1] == 1'b0));

endmodule

// File: tb/sas_top_tb_top.sv
module sas_top_tb_top;
    import sas_pkg::*;

    localparam int EXP_W = 16;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid, in_ready, in_sign, in_round, in_sticky;
    logic [EXP_W-1:0] in_exp;
    logic [1:0]       in_class;
    logic [127:0]     in_sig;
    logic [CNT_W-1:0] in_shift;
    logic             out_valid, out_ready, out_sign, out_round, out_sticky;
    logic [EXP_W-1:0] out_exp;
    logic [1:0]       out_class;
    logic [127:0]     out_sig;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    sas_top dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_sign(in_sign), .in_exp(in_exp), .in_class(in_class),
        .in_sig(in_sig), .in_round(in_round), .in_sticky(in_sticky),
        .in_shift(in_shift),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sign(out_sign), .out_exp(out_exp), .out_class(out_class),
        .out_sig(out_sig), .out_round(out_round), .out_sticky(out_sticky)
    );

    typedef struct {
        logic [1:0]   c;
        logic [127:0] s;
        logic         r;
        logic         st;
    } exp_t;

    // Bit-serial model: one position at a time.
    function automatic exp_t model(input logic [1:0] c, input logic [127:0] s,
                                   input logic r, input logic st,
                                   input logic [7:0] n);
        exp_t e;
        e.c = c; e.s = s; e.r = r; e.st = st;
        if (c == 2'd1) begin
            if (n > 8'd113) begin
                if (s == '0) e.c = 2'd0;
                else begin e.s = '0; e.r = 1'b0; e.st = 1'b1; end
            end else begin
                for (int i = 0; i < int'(n); i++) begin
                    e.st = e.st | e.r;
                    e.r  = e.s[0];
                    e.s  = e.s >> 1;
                end
            end
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [1:0] c, input logic [127:0] s,
                                     input logic [7:0] n);
        if (c != 2'd1) return "R7";
        if (n > 8'd113) return (s == '0) ? "R5" : "R6";
        if (n == 0) return "R1";
        return "R2/R3/R4";
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    task automatic send(input logic [1:0] c, input logic [127:0] s,
                        input logic r, input logic st, input logic [7:0] n);
        exp_t e;
        logic [15:0] ex;
        logic sg;
        string t;
        ex = 16'($urandom);
        sg = 1'($urandom);
        e  = model(c, s, r, st, n);
        t  = tag_of(c, s, n);
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b1;
        in_class = c; in_sig = s; in_round = r; in_sticky = st;
        in_shift = n; in_exp = ex; in_sign = sg;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_sign == sg && out_exp == ex, "R8",
              $sformatf("valid/sign/exp act=%b/%b/%h exp=1/%b/%h",
                        out_valid, out_sign, out_exp, sg, ex));
        check(out_class == e.c && out_sig == e.s && out_round == e.r
              && out_sticky == e.st, t,
              $sformatf("n=%0d act c=%0d s=%h r=%b st=%b exp c=%0d s=%h r=%b st=%b",
                        n, out_class, out_sig, out_round, out_sticky,
                        e.c, e.s, e.r, e.st));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [127:0] pat;
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        in_sign = 0; in_exp = 0; in_class = 0; in_sig = 0;
        in_round = 0; in_sticky = 0; in_shift = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R9",
              $sformatf("reset act valid=%b ready=%b exp 0/1", out_valid, in_ready));

        pat = {32'h8000_0001, 32'hdead_beef, 32'h0000_0001, 32'h8000_0003};
        send(2'd1, pat, 1'b1, 1'b0, 8'd0);    // R1
        send(2'd1, pat, 1'b0, 1'b0, 8'd1);
        send(2'd1, pat, 1'b1, 1'b0, 8'd31);
        send(2'd1, pat, 1'b0, 1'b0, 8'd32);
        send(2'd1, pat, 1'b0, 1'b1, 8'd33);
        send(2'd1, pat, 1'b0, 1'b0, 8'd64);
        send(2'd1, pat, 1'b0, 1'b0, 8'd96);
        send(2'd1, pat, 1'b0, 1'b0, 8'd113);
        send(2'd1, 128'h1 << 112, 1'b0, 1'b0, 8'd113); // R3 round from top bit
        send(2'd1, 128'h1 << 127, 1'b0, 1'b0, 8'd113); // R2 zero fill
        send(2'd1, pat, 1'b1, 1'b0, 8'd114);  // R6
        send(2'd1, 128'h1, 1'b0, 1'b0, 8'd255); // R6
        send(2'd1, '0, 1'b1, 1'b0, 8'd200);   // R5
        send(2'd1, '0, 1'b0, 1'b0, 8'd50);    // R2 zero stays normal
        send(2'd2, pat, 1'b1, 1'b1, 8'd10);   // R7
        send(2'd3, pat, 1'b0, 1'b1, 8'd200);  // R7
        send(2'd0, '0, 1'b1, 1'b0, 8'd255);   // R7

        // R9 backpressure
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b0;
        in_class = 2'd1; in_sig = pat; in_round = 0; in_sticky = 0; in_shift = 8'd4;
        @(negedge clk);
        in_sig = ~pat; in_shift = 8'd40;
        check(out_valid && !in_ready, "R9",
              $sformatf("hold act valid=%b ready=%b exp 1/0", out_valid, in_ready));
        @(negedge clk);
        check(out_valid && out_sig == (pat >> 4), "R9",
              $sformatf("stable act=%h exp=%h", out_sig, pat >> 4));
        in_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R9",
              $sformatf("drain act valid=%b exp 0", out_valid));

        for (int k = 0; k < 400; k++) begin
            logic [127:0] s;
            logic [1:0]   c;
            logic [7:0]   n;
            s = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(0, 3) == 0) s = s & ({$urandom, $urandom, $urandom, $urandom});
            if ($urandom_range(0, 15) == 0) s = '0;
            c = ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'd1;
            n = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'($urandom_range(0, 120));
            send(c, s, 1'($urandom), 1'($urandom), n);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule